// File: doc/BRIEF.md
# Iterative AES-128 Block Encryptor

This block encrypts one 128-bit block under a 128-bit cipher key with AES-128. A single start strobe captures the plaintext and the key. After that the engine performs one full cipher round per clock, using sixteen parallel S-box units on a single 128-bit loop register. The round keys are expanded alongside the datapath, one key per round, so a fresh key can be presented with every block and costs no setup cycles.

The round loop is reordered. The loop register always holds a value that has just had a round key added. Every iteration applies byte substitution, the row rotation, column mixing and the next round key. The final round must not mix columns. For that round the ciphertext is taken from the row-rotated S-box output and passes through a separate key-addition XOR into the output register. No select path sits inside the loop. The result appears with a one-cycle completion pulse and is held until the next block finishes.

Top module: `aes128_iter_enc`

## Requirements
- R1: While reset is asserted and after it is released with no request, `done` is 0 and `ciphertext` is all zeros.
- R2: The ciphertext equals AES-128 encryption of the plaintext under the key. The initial key addition, ten rounds, the key schedule constants 01,02,04,08,10,20,40,80,1B,36 and a last round without column mixing are all included. Byte 0 of a block is bits [127:120], and bytes fill the state column by column.
- R3: `done` rises on the 10th rising clock edge after the edge that samples `start`.
- R4: `done` is high for exactly one cycle per block. `ciphertext` is valid in that cycle and stays unchanged until the next `done`.
- R5: A `start` pulse that arrives while a block is in progress is ignored. It produces no extra `done`, and the running block's result is unaffected.
- R6: `plaintext` and `key` are sampled only at the accepted `start`. Changing them during the run does not alter the result.
- R7: A `start` presented during the cycle in which `done` is high is accepted, and its result follows 10 edges later.
- R8: A fresh key with each block needs no extra cycles. Consecutive blocks with different keys each complete with the R3 latency and the correct R2 value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to encrypt; sampled when idle |
| plaintext | input | 128 | Block to encrypt, byte 0 in bits [127:120] |
| key | input | 128 | Cipher key, same byte order |
| ciphertext | output | 128 | Encrypted block, held between completions |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check the control behaviour on every cycle. They cover the single-cycle completion pulse, that a pulse comes only from the tenth round of a running block, that a start during a run leaves the round count advancing undisturbed, and that the output is held between completions. The correctness of the cipher value, the key schedule constants and the last-round handling can only be shown by the scenarios. These compare results against known-answer vectors, with inputs changed mid-run, an ignored start, back-to-back blocks and a new key for each block.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int BLK_W  = 128;
  localparam int BYTE_W = 8;
  localparam int NBYTES = BLK_W / BYTE_W;

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic byte_t gf_xtime(input byte_t b);
    gf_xtime = {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(input byte_t a, input byte_t b);
    byte_t p;
    byte_t t;
    p = '0;
    t = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) p = p ^ t;
      t = gf_xtime(t);
    end
    gf_mul = p;
  endfunction

  // a^254 is the field inverse for a != 0 and maps 0 to 0
  function automatic byte_t gf_inv(input byte_t a);
    byte_t r;
    byte_t base;
    r = 8'h01;
    base = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    gf_inv = r;
  endfunction

  function automatic byte_t rotl8(input byte_t b, input int n);
    rotl8 = byte_t'((b << n) | (b >> (BYTE_W - n)));
  endfunction

  function automatic byte_t sub_byte(input byte_t a);
    byte_t s;
    s = gf_inv(a);
    sub_byte = s ^ rotl8(s, 1) ^ rotl8(s, 2) ^ rotl8(s, 3) ^ rotl8(s, 4) ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes128_sbox.sv
module aes128_sbox
  import aes128_pkg::*;
(
  input  byte_t din,
  output byte_t dout
);
  assign dout = sub_byte(din);
endmodule

// File: rtl/aes128_round_path.sv
module aes128_round_path
  import aes128_pkg::*;
(
  input  blk_t st_in,
  output blk_t shifted,
  output blk_t mixed
);
  localparam int ROWS = 4;
  localparam int COLS = NBYTES / ROWS;

  blk_t subbed;

  for (genvar i = 0; i < NBYTES; i++) begin : g_sub
    aes128_sbox u_sb (
      .din  (st_in[BLK_W-1-BYTE_W*i -: BYTE_W]),
      .dout (subbed[BLK_W-1-BYTE_W*i -: BYTE_W])
    );
  end

  // row r of column c takes the byte from column (c + r) mod COLS
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int SRC = ((c + r) % COLS) * ROWS + r;
      localparam int DST = c * ROWS + r;
      assign shifted[BLK_W-1-BYTE_W*DST -: BYTE_W] = subbed[BLK_W-1-BYTE_W*SRC -: BYTE_W];
    end

    byte_t a0, a1, a2, a3;
    assign a0 = shifted[BLK_W-1-BYTE_W*(c*ROWS+0) -: BYTE_W];
    assign a1 = shifted[BLK_W-1-BYTE_W*(c*ROWS+1) -: BYTE_W];
    assign a2 = shifted[BLK_W-1-BYTE_W*(c*ROWS+2) -: BYTE_W];
    assign a3 = shifted[BLK_W-1-BYTE_W*(c*ROWS+3) -: BYTE_W];
    assign mixed[BLK_W-1-BYTE_W*(c*ROWS+0) -: BYTE_W] = gf_xtime(a0) ^ gf_xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(c*ROWS+1) -: BYTE_W] = a0 ^ gf_xtime(a1) ^ gf_xtime(a2) ^ a2 ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(c*ROWS+2) -: BYTE_W] = a0 ^ a1 ^ gf_xtime(a2) ^ gf_xtime(a3) ^ a3;
    assign mixed[BLK_W-1-BYTE_W*(c*ROWS+3) -: BYTE_W] = gf_xtime(a0) ^ a0 ^ a1 ^ a2 ^ gf_xtime(a3);
  end
endmodule

// File: rtl/aes128_key_step.sv
module aes128_key_step
  import aes128_pkg::*;
(
  input  blk_t  rk_in,
  input  byte_t rcon,
  output blk_t  rk_out
);
  localparam int WORD_W = 32;
  localparam int WBYTES = WORD_W / BYTE_W;

  logic [WORD_W-1:0] w0, w1, w2, w3, rot, subw, mixw, n0, n1, n2, n3;

  assign {w0, w1, w2, w3} = rk_in;
  assign rot = {w3[23:0], w3[31:24]};

  for (genvar j = 0; j < WBYTES; j++) begin : g_ksb
    aes128_sbox u_ksb (
      .din  (rot[WORD_W-1-BYTE_W*j -: BYTE_W]),
      .dout (subw[WORD_W-1-BYTE_W*j -: BYTE_W])
    );
  end

  assign mixw = subw ^ {rcon, 24'h000000};
  assign n0 = w0 ^ mixw;
  assign n1 = w1 ^ n0;
  assign n2 = w2 ^ n1;
  assign n3 = w3 ^ n2;
  assign rk_out = {n0, n1, n2, n3};
endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
  import aes128_pkg::*;
#(
  parameter int ROUNDS = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] plaintext,
  input  logic [127:0] key,
  output logic [127:0] ciphertext,
  output logic         done
);
  localparam int RW = $clog2(ROUNDS + 1);
  localparam logic [RW-1:0] LAST_IDX = RW'(ROUNDS - 1);

  logic          busy_q, busy_d;
  logic [RW-1:0] rnd_q, rnd_d;
  blk_t          st_q, st_d, rk_q, rk_d, ct_q, ct_d;
  byte_t         rcon_q, rcon_d;
  logic          done_q, done_d;
  logic          go, last, loop_en, out_en;
  blk_t          shifted, mixed, rk_nx;

  aes128_round_path u_round (
    .st_in   (st_q),
    .shifted (shifted),
    .mixed   (mixed)
  );

  aes128_key_step u_key (
    .rk_in  (rk_q),
    .rcon   (rcon_q),
    .rk_out (rk_nx)
  );

  assign go      = start & ~busy_q;
  assign last    = busy_q & (rnd_q == LAST_IDX);
  assign loop_en = go | busy_q;
  assign out_en  = last;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    st_d   = st_q;
    rk_d   = rk_q;
    rcon_d = rcon_q;
    ct_d   = ct_q;
    done_d = 1'b0;
    if (go) begin
      busy_d = 1'b1;
      rnd_d  = '0;
      st_d   = plaintext ^ key;
      rk_d   = key;
      rcon_d = 8'h01;
    end else if (busy_q) begin
      rnd_d  = rnd_q + 1'b1;
      st_d   = mixed ^ rk_nx;
      rk_d   = rk_nx;
      rcon_d = gf_xtime(rcon_q);
      if (last) begin
        busy_d = 1'b0;
        ct_d   = shifted ^ rk_nx;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      st_q   <= '0;
      rk_q   <= '0;
      rcon_q <= '0;
      ct_q   <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (loop_en) begin
        rnd_q  <= rnd_d;
        st_q   <= st_d;
        rk_q   <= rk_d;
        rcon_q <= rcon_d;
      end
      if (out_en) ct_q <= ct_d;
    end
  end

  assign ciphertext = ct_q;
  assign done       = done_q;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_from_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy_q) && $past(rnd_q) == LAST_IDX));

  assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && rnd_q != LAST_IDX) |=> (busy_q && rnd_q == $past(rnd_q) + 1'b1));

  assert_ct_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ciphertext));

  assert_rcon_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> rcon_q != 8'h00);
endmodule

// File: tb/aes128_iter_enc_test.sv
module aes128_iter_enc_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] plaintext, key;
  logic [127:0] ciphertext;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [127:0] exp_q[$];
  int           cyc_q[$];
  logic [127:0] last_ct;
  logic         have_ct = 1'b0;
  logic         prev_done = 1'b0;
  logic         finished = 1'b0;

  localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] C2 = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] C0 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

  aes128_iter_enc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .plaintext(plaintext),
    .key(key), .ciphertext(ciphertext), .done(done)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops the scoreboard on each completion
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        checks++;
        if (prev_done) begin
          errors++;
          $display("FAIL R4 done high two cycles actual=1 expected=0");
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5 unexpected done actual ct=%h expected no completion", ciphertext);
        end else begin
          logic [127:0] e;
          int sc;
          e = exp_q.pop_front();
          sc = cyc_q.pop_front();
          checks++;
          if (ciphertext !== e) begin
            errors++;
            $display("FAIL R2/R6 ciphertext actual=%h expected=%h", ciphertext, e);
          end
          checks++;
          // start driven at cycle sc, sampled at edge sc+1, done after edge sc+11
          if (cyc - sc != 11) begin
            errors++;
            $display("FAIL R3 latency actual=%0d expected=11", cyc - sc);
          end
        end
        last_ct = ciphertext;
        have_ct = 1'b1;
      end else if (have_ct) begin
        checks++;
        if (ciphertext !== last_ct) begin
          errors++;
          $display("FAIL R4 hold actual=%h expected=%h", ciphertext, last_ct);
        end
      end
      prev_done = done;
    end
  end

  // driver: called at a negedge, leaves at the following negedge
  task automatic issue(input logic [127:0] p, input logic [127:0] k, input logic [127:0] e);
    plaintext = p;
    key = k;
    start = 1'b1;
    exp_q.push_back(e);
    cyc_q.push_back(cyc);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    plaintext = '0;
    key = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || ciphertext !== '0) begin
      errors++;
      $display("FAIL R1 in reset actual done=%b ct=%h expected 0/0", done, ciphertext);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 1'b0 || ciphertext !== '0) begin
      errors++;
      $display("FAIL R1 idle actual done=%b ct=%h expected 0/0", done, ciphertext);
    end

    // R2: known-answer vector
    issue(P1, K1, C1);
    wait_done();
    repeat (2) @(negedge clk);

    // R6: inputs scrambled right after the start is taken
    issue(P2, K2, C2);
    plaintext = 128'hdeadbeef_0badf00d_12345678_9abcdef0;
    key = 128'hffffffff_00000000_a5a5a5a5_5a5a5a5a;
    repeat (3) @(negedge clk);
    // R5: start while busy is ignored
    plaintext = '0;
    key = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();

    // R7: new start in the done cycle; R8: fresh key every block
    issue('0, '0, C0);
    wait_done();
    issue(P1, K1, C1);
    wait_done();
    issue(P2, K2, C2);
    wait_done();

    // R5: no stray completion afterwards
    repeat (20) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending results actual=%0d expected=0", exp_q.size());
    end
    summary();
  end

  initial begin
    #20000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule